// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks loads that a compiler has moved ahead of stores that might write the same memory. When such a load issues, the table records which register it filled and which aligned memory block it read. Every store compares its address with all recorded blocks and drops each entry that falls in the same block. Later, a check on the destination register asks whether the entry is still present. A hit means no intervening store touched the data, so the early load was safe. A miss reports a conflict, and recovery code then re-executes the load.

The table is fully associative. An insert whose register number is already present overwrites that entry, so no register ever owns two entries. Otherwise the insert takes the lowest-numbered free entry. When no entry is free, a round-robin pointer chooses the entry to replace. A check may also ask for its matched entry to be removed. A flush input, like reset, empties the whole table.

Top module: `ld_spec_table`

## Requirements
- R1: After reset, and in the cycle after `flush_i` is high, the table holds no entries and every check reports a miss. A flush also resets the replacement pointer to entry 0. An insert in the same cycle as a flush is dropped.
- R2: An insert records `ins_reg_i` together with the aligned block of `ins_addr_i`, which is bits ADDR_W-1 down to ALIGN_LSB. A later check on that register reports a hit.
- R3: A check presented in cycle t returns its result on `chk_done_o`, `chk_hit_o` and `chk_miss_o` in cycle t+1. `chk_done_o` is high for exactly that one cycle. Exactly one of `chk_hit_o` and `chk_miss_o` is high, and both are low when `chk_done_o` is low. The result reflects the table as it stood before any update made in cycle t.
- R4: A store removes every entry whose aligned block equals the aligned block of `st_addr_i`. Address bits below ALIGN_LSB are ignored, and entries in other blocks are left unchanged.
- R5: An insert whose register number matches a live entry overwrites that entry's block. The old block then no longer matches stores.
- R6: An insert with no register match takes the lowest-numbered free entry. An entry freed by a store or a check-and-clear in the same cycle counts as free.
- R7: When every entry is live and no register matches, the insert replaces the entry at the round-robin pointer. The pointer starts at 0, moves up by one after each such replacement, and wraps from ENTRIES-1 to 0.
- R8: When a store and an insert arrive in the same cycle, the store's invalidation is applied first and the new entry is written afterwards. An insert in the same block as the store therefore survives.
- R9: A check with `chk_clear_i` high removes its matched entry after reporting the hit. A check with `chk_clear_i` low leaves the entry in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empties the table |
| ins_valid_i | input | 1 | Insert request from a speculative load |
| ins_reg_i | input | REG_W | Destination register number of the load |
| ins_addr_i | input | ADDR_W | Address read by the load |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | ADDR_W | Address written by the store |
| chk_valid_i | input | 1 | Check request |
| chk_clear_i | input | 1 | Removes the matched entry on a hit |
| chk_reg_i | input | REG_W | Register number being checked |
| chk_done_o | output | 1 | Check result is valid |
| chk_hit_o | output | 1 | Entry present, so the speculation held |
| chk_miss_o | output | 1 | Conflict, so the load must be re-executed |

## Verification
The bench builds the table with ENTRIES=4, ADDR_W=16, REG_W=6, ALIGN_LSB=3 and a registered result. With only four entries, a few inserts fill the table. This brings within reach the reuse of the lowest free entry after clears, a full cycle of the round-robin pointer, and its wrap back to entry 0. Addresses that differ only below bit 3, or just above it, probe the exact edge of the 8-byte overlap rule. Same-cycle pairings probe the ordering rules: store with insert, flush with insert, and check with insert.

// File: rtl/slt_pkg.sv
package slt_pkg;
   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_MATCH,
      SRC_FREE,
      SRC_VICTIM
   } alloc_src_e;
endpackage

// File: rtl/slt_entry.sv
module slt_entry #(
   parameter int REG_W = 6,
   parameter int TAG_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [REG_W-1:0] wr_reg_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic             clr_i,
   input  logic [REG_W-1:0] chk_reg_i,
   input  logic [REG_W-1:0] ins_reg_i,
   input  logic [TAG_W-1:0] st_tag_i,
   output logic             valid_o,
   output logic             chk_eq_o,
   output logic             ins_eq_o,
   output logic             st_eq_o
);
   logic             valid_q;
   logic [REG_W-1:0] reg_q;
   logic [TAG_W-1:0] tag_q;

   // a write wins over a clear: the kill is ordered before the new entry
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         reg_q   <= '0;
         tag_q   <= '0;
      end else if (wr_i) begin
         valid_q <= 1'b1;
         reg_q   <= wr_reg_i;
         tag_q   <= wr_tag_i;
      end else if (clr_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o  = valid_q;
   assign chk_eq_o = valid_q && (reg_q == chk_reg_i);
   assign ins_eq_o = valid_q && (reg_q == ins_reg_i);
   assign st_eq_o  = valid_q && (tag_q == st_tag_i);

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (valid_q && reg_q == $past(wr_reg_i) && tag_q == $past(wr_tag_i)));

   assert_kill_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !wr_i) |=> !valid_q);
endmodule

// File: rtl/slt_alloc.sv
module slt_alloc
   import slt_pkg::*;
#(
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic               req_i,
   input  logic [ENTRIES-1:0] match_vec_i,
   input  logic [ENTRIES-1:0] free_vec_i,
   output logic [ENTRIES-1:0] wr_vec_o
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0]   ptr_q;
   alloc_src_e         src;
   logic [ENTRIES-1:0] first_free;
   logic [ENTRIES-1:0] victim_vec;

   // walk downward so the lowest free index is the last one kept
   always_comb begin
      first_free = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (free_vec_i[i]) begin
            first_free    = '0;
            first_free[i] = 1'b1;
         end
      end
   end

   always_comb begin
      victim_vec        = '0;
      victim_vec[ptr_q] = 1'b1;
   end

   always_comb begin
      if (!req_i)                 src = SRC_NONE;
      else if (|match_vec_i)      src = SRC_MATCH;
      else if (|free_vec_i)       src = SRC_FREE;
      else                        src = SRC_VICTIM;
   end

   always_comb begin
      unique case (src)
         SRC_MATCH:  wr_vec_o = match_vec_i;
         SRC_FREE:   wr_vec_o = first_free;
         SRC_VICTIM: wr_vec_o = victim_vec;
         default:    wr_vec_o = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         ptr_q <= '0;
      end else if (src == SRC_VICTIM) begin
         ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
      end
   end

   assert_one_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_vec_o));

   assert_req_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |-> ($countones(wr_vec_o) == 1));

   assert_prefer_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && match_vec_i == '0 && free_vec_i != '0) |-> ((wr_vec_o & ~free_vec_i) == '0));

   assert_rr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !flush_i && match_vec_i == '0 && free_vec_i == '0) |=>
      (ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : $past(ptr_q) + 1'b1)));
endmodule

// File: rtl/slt_result.sv
module slt_result #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid_i,
   input  logic hit_i,
   output logic done_o,
   output logic hit_o,
   output logic miss_o
);
   generate
      if (REGISTERED) begin : g_reg
         logic done_q, hit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               done_q <= 1'b0;
               hit_q  <= 1'b0;
            end else begin
               done_q <= valid_i;
               hit_q  <= valid_i && hit_i;
            end
         end
         assign done_o = done_q;
         assign hit_o  = hit_q;

         assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i |=> done_o);
         assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i |=> !done_o);
      end else begin : g_comb
         assign done_o = valid_i;
         assign hit_o  = valid_i && hit_i;
      end
   endgenerate

   assign miss_o = done_o && !hit_o;

   assert_hit_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> done_o);
endmodule

// File: rtl/ld_spec_table.sv
module ld_spec_table #(
   parameter int ENTRIES    = 8,
   parameter int REG_W      = 6,
   parameter int ADDR_W     = 32,
   parameter int ALIGN_LSB  = 3,
   parameter bit RESULT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              ins_valid_i,
   input  logic [REG_W-1:0]  ins_reg_i,
   input  logic [ADDR_W-1:0] ins_addr_i,
   input  logic              st_valid_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic              chk_valid_i,
   input  logic              chk_clear_i,
   input  logic [REG_W-1:0]  chk_reg_i,
   output logic              chk_done_o,
   output logic              chk_hit_o,
   output logic              chk_miss_o
);
   localparam int TAG_W = ADDR_W - ALIGN_LSB;

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("ld_spec_table: ENTRIES must be at least 2");
      end
      if (REG_W < 1) begin : g_bad_reg
         $error("ld_spec_table: REG_W must be at least 1");
      end
      if (ALIGN_LSB < 1 || ALIGN_LSB >= ADDR_W) begin : g_bad_align
         $error("ld_spec_table: ALIGN_LSB must lie in 1..ADDR_W-1");
      end
   endgenerate

   logic [TAG_W-1:0]   ins_tag, st_tag;
   logic               unused_low_bits;
   logic [ENTRIES-1:0] valid_vec, chk_eq, ins_eq, st_eq;
   logic [ENTRIES-1:0] st_kill, chk_kill, clr_vec, free_vec, wr_vec;
   logic               ins_req;

   assign ins_tag         = ins_addr_i[ADDR_W-1:ALIGN_LSB];
   assign st_tag          = st_addr_i[ADDR_W-1:ALIGN_LSB];
   assign unused_low_bits = ^{ins_addr_i[ALIGN_LSB-1:0], st_addr_i[ALIGN_LSB-1:0]};

   assign st_kill  = st_valid_i ? st_eq : '0;
   assign chk_kill = (chk_valid_i && chk_clear_i) ? chk_eq : '0;
   assign clr_vec  = st_kill | chk_kill | {ENTRIES{flush_i}};
   assign free_vec = ~valid_vec | st_kill | chk_kill;
   assign ins_req  = ins_valid_i && !flush_i;

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
         slt_entry #(.REG_W(REG_W), .TAG_W(TAG_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_vec[e]),
            .wr_reg_i  (ins_reg_i),
            .wr_tag_i  (ins_tag),
            .clr_i     (clr_vec[e]),
            .chk_reg_i (chk_reg_i),
            .ins_reg_i (ins_reg_i),
            .st_tag_i  (st_tag),
            .valid_o   (valid_vec[e]),
            .chk_eq_o  (chk_eq[e]),
            .ins_eq_o  (ins_eq[e]),
            .st_eq_o   (st_eq[e])
         );
      end
   endgenerate

   slt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush_i),
      .req_i       (ins_req),
      .match_vec_i (ins_eq),
      .free_vec_i  (free_vec),
      .wr_vec_o    (wr_vec)
   );

   slt_result #(.REGISTERED(RESULT_REG)) u_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (chk_valid_i),
      .hit_i   (|chk_eq),
      .done_o  (chk_done_o),
      .hit_o   (chk_hit_o),
      .miss_o  (chk_miss_o)
   );

   assert_reg_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chk_eq));

   assert_flush_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (valid_vec == '0));

   assert_store_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid_i && !ins_valid_i) |=> ((valid_vec & $past(st_eq)) == '0));

   assert_store_then_insert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid_i && st_valid_i && !flush_i && ins_tag == st_tag) |=> (valid_vec != '0));

   assert_clear_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid_i && chk_clear_i && !ins_valid_i) |=> ((valid_vec & $past(chk_eq)) == '0));

   assert_plain_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid_i && !chk_clear_i && !st_valid_i && !flush_i) |=>
      ((valid_vec & $past(chk_eq)) == $past(chk_eq)));
endmodule

// File: tb/sim_ld_spec_table.sv
`timescale 1ns/1ps
module sim_ld_spec_table;
   localparam int ENTRIES = 4;
   localparam int REG_W   = 6;
   localparam int ADDR_W  = 16;

   // operation kinds
   localparam logic [2:0] K_INS = 3'd1, K_ST = 3'd2, K_CHK = 3'd3, K_CHKC = 3'd4,
                          K_FLUSH = 3'd5, K_INSST = 3'd6, K_INSCHK = 3'd7;
   localparam int NVEC = 48;

   // {kind[29:27], req[26:23], reg[22:17], addr[16:1], expected hit[0]}
   localparam logic [29:0] VEC [NVEC] = '{
      {K_CHK,   4'd1, 6'd5,  16'h0000, 1'b0}, // R1 empty after reset
      {K_INS,   4'd2, 6'd5,  16'h0100, 1'b0},
      {K_CHK,   4'd2, 6'd5,  16'h0000, 1'b1}, // R2
      {K_CHK,   4'd2, 6'd6,  16'h0000, 1'b0}, // R2 other reg
      {K_INS,   4'd4, 6'd6,  16'h0208, 1'b0},
      {K_ST,    4'd4, 6'd0,  16'h0107, 1'b0}, // R4 same 8-byte block as 0x0100
      {K_CHK,   4'd4, 6'd5,  16'h0000, 1'b0},
      {K_CHK,   4'd4, 6'd6,  16'h0000, 1'b1},
      {K_ST,    4'd4, 6'd0,  16'h0210, 1'b0}, // R4 neighbour block
      {K_CHK,   4'd4, 6'd6,  16'h0000, 1'b1},
      {K_INS,   4'd5, 6'd6,  16'h0300, 1'b0}, // R5 overwrite
      {K_ST,    4'd5, 6'd0,  16'h0208, 1'b0},
      {K_CHK,   4'd5, 6'd6,  16'h0000, 1'b1},
      {K_ST,    4'd5, 6'd0,  16'h0300, 1'b0},
      {K_CHK,   4'd5, 6'd6,  16'h0000, 1'b0},
      {K_INS,   4'd9, 6'd7,  16'h0400, 1'b0},
      {K_CHKC,  4'd9, 6'd7,  16'h0000, 1'b1}, // R9 clear on hit
      {K_CHK,   4'd9, 6'd7,  16'h0000, 1'b0},
      {K_INS,   4'd9, 6'd8,  16'h0500, 1'b0},
      {K_CHK,   4'd9, 6'd8,  16'h0000, 1'b1}, // R9 plain check keeps
      {K_CHK,   4'd9, 6'd8,  16'h0000, 1'b1},
      {K_INSST, 4'd8, 6'd9,  16'h0500, 1'b0}, // R8 store then insert
      {K_CHK,   4'd8, 6'd9,  16'h0000, 1'b1},
      {K_CHK,   4'd8, 6'd8,  16'h0000, 1'b0},
      {K_FLUSH, 4'd1, 6'd0,  16'h0000, 1'b0},
      {K_CHK,   4'd1, 6'd9,  16'h0000, 1'b0}, // R1 flush
      {K_INS,   4'd6, 6'd1,  16'h1000, 1'b0},
      {K_INS,   4'd6, 6'd2,  16'h1008, 1'b0},
      {K_INS,   4'd6, 6'd3,  16'h1010, 1'b0},
      {K_INS,   4'd6, 6'd4,  16'h1018, 1'b0},
      {K_CHKC,  4'd9, 6'd2,  16'h0000, 1'b1}, // frees entry 1
      {K_CHKC,  4'd9, 6'd3,  16'h0000, 1'b1}, // frees entry 2
      {K_INS,   4'd6, 6'd5,  16'h1020, 1'b0}, // R6 goes to entry 1
      {K_INS,   4'd6, 6'd6,  16'h1028, 1'b0}, // entry 2
      {K_INS,   4'd7, 6'd7,  16'h1030, 1'b0}, // R7 replaces entry 0
      {K_CHK,   4'd7, 6'd1,  16'h0000, 1'b0},
      {K_INS,   4'd7, 6'd8,  16'h1038, 1'b0}, // replaces entry 1
      {K_CHK,   4'd6, 6'd5,  16'h0000, 1'b0}, // R6 proves reg 5 sat in entry 1
      {K_CHK,   4'd6, 6'd6,  16'h0000, 1'b1},
      {K_CHK,   4'd7, 6'd4,  16'h0000, 1'b1},
      {K_INS,   4'd7, 6'd9,  16'h1040, 1'b0}, // entry 2
      {K_INS,   4'd7, 6'd10, 16'h1048, 1'b0}, // entry 3
      {K_INS,   4'd7, 6'd11, 16'h1050, 1'b0}, // R7 wrap to entry 0
      {K_CHK,   4'd7, 6'd7,  16'h0000, 1'b0},
      {K_CHK,   4'd7, 6'd8,  16'h0000, 1'b1},
      {K_CHK,   4'd7, 6'd11, 16'h0000, 1'b1},
      {K_INSCHK,4'd3, 6'd12, 16'h1058, 1'b0}, // R3 check sees pre-update table
      {K_CHK,   4'd3, 6'd12, 16'h0000, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              flush_i, ins_valid_i, st_valid_i, chk_valid_i, chk_clear_i;
   logic [REG_W-1:0]  ins_reg_i, chk_reg_i;
   logic [ADDR_W-1:0] ins_addr_i, st_addr_i;
   logic              chk_done_o, chk_hit_o, chk_miss_o;
   int                n_checks = 0;
   int                n_fails  = 0;
   int                cycles   = 0;

   always #2.5 clk = ~clk;

   ld_spec_table #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W),
                   .ALIGN_LSB(3), .RESULT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .ins_valid_i(ins_valid_i), .ins_reg_i(ins_reg_i), .ins_addr_i(ins_addr_i),
      .st_valid_i(st_valid_i), .st_addr_i(st_addr_i),
      .chk_valid_i(chk_valid_i), .chk_clear_i(chk_clear_i), .chk_reg_i(chk_reg_i),
      .chk_done_o(chk_done_o), .chk_hit_o(chk_hit_o), .chk_miss_o(chk_miss_o)
   );

   task automatic idle_inputs();
      flush_i = 0; ins_valid_i = 0; st_valid_i = 0; chk_valid_i = 0; chk_clear_i = 0;
      ins_reg_i = '0; chk_reg_i = '0; ins_addr_i = '0; st_addr_i = '0;
   endtask

   task automatic expect_result(input int req, input logic is_chk, input logic exp_hit);
      n_checks++;
      if (is_chk) begin
         if (chk_done_o !== 1'b1 || chk_hit_o !== exp_hit || chk_miss_o !== !exp_hit) begin
            n_fails++;
            $display("FAIL R%0d check: done=%b hit=%b miss=%b, expected done=1 hit=%b miss=%b",
                     req, chk_done_o, chk_hit_o, chk_miss_o, exp_hit, !exp_hit);
         end
      end else if (chk_done_o !== 1'b0 || chk_hit_o !== 1'b0 || chk_miss_o !== 1'b0) begin
         n_fails++;
         $display("FAIL R3 idle result: done=%b hit=%b miss=%b, expected 0 0 0",
                  chk_done_o, chk_hit_o, chk_miss_o);
      end
   endtask

   // called at a falling edge; drives one cycle of stimulus and checks its result
   task automatic run_op(input logic [2:0] kind, input int req, input logic [REG_W-1:0] r,
                         input logic [ADDR_W-1:0] a, input logic exp_hit);
      logic is_chk;
      is_chk = (kind == K_CHK) || (kind == K_CHKC) || (kind == K_INSCHK);
      idle_inputs();
      if (kind == K_INS || kind == K_INSST || kind == K_INSCHK) begin
         ins_valid_i = 1; ins_reg_i = r; ins_addr_i = a;
      end
      if (kind == K_ST || kind == K_INSST) begin
         st_valid_i = 1; st_addr_i = a;
      end
      if (is_chk) begin
         chk_valid_i = 1; chk_reg_i = r; chk_clear_i = (kind == K_CHKC);
      end
      if (kind == K_FLUSH) flush_i = 1;
      @(negedge clk);
      idle_inputs();
      expect_result(req, is_chk, exp_hit);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_fails++;
         $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state of the result outputs
      expect_result(1, 1'b0, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i][29:27], int'(VEC[i][26:23]), VEC[i][22:17], VEC[i][16:1], VEC[i][0]);
      end

      // R3 result pulses once: an idle cycle follows with all outputs low
      run_op(K_CHK, 3, 6'd12, '0, 1'b1);
      @(negedge clk);
      expect_result(3, 1'b0, 1'b0);

      // R1 insert in the same cycle as a flush is dropped
      idle_inputs();
      flush_i = 1; ins_valid_i = 1; ins_reg_i = 6'd13; ins_addr_i = 16'h2000;
      @(negedge clk);
      idle_inputs();
      run_op(K_CHK, 1, 6'd13, '0, 1'b0);
      run_op(K_CHK, 1, 6'd11, '0, 1'b0);

      // R9 check-and-clear on a miss leaves other entries alone
      run_op(K_INS, 9, 6'd20, 16'h3000, 1'b0);
      run_op(K_CHKC, 9, 6'd21, '0, 1'b0);
      run_op(K_CHK, 9, 6'd20, '0, 1'b1);

      // R1 mid-run reset empties the table
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      run_op(K_CHK, 1, 6'd20, '0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule